// File: doc/BRIEF.md
# DRAM ECC Error Logging Unit

This block records DRAM ECC error events for a two-channel memory controller and presents them to a host through a small register port. An upstream ECC checker reports correctable (single-bit) and uncorrectable (multi-bit) events. Each event carries a 33-bit physical address, the channel of the failing access and an 8-bit syndrome. Three other event lines can also raise flags: refresh timeout, locked access to non-DRAM space, and a thermal sensor trip.

The captured address is kept at 128-byte granularity. Once an uncorrectable error is logged, the capture registers are frozen. A correctable error can only fill empty capture registers. An uncorrectable error that arrives after a correctable error replaces that error's capture, and the correctable flag stays set. Software can therefore see that an overwrite happened. A command register selects which flags drive the system-error output.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads 0 and `serr_o` is low.
- R2: Register select values are 0 status, 1 command, 2 address pointer, 3 extended pointer and 4 syndrome. Any other select reads 0. In the status and command words, the only defined bits are 0 (correctable ECC), 1 (uncorrectable ECC), 8 (refresh timeout), 9 (lock to non-DRAM) and 11 (thermal). Every other bit reads 0.
- R3: An active event input sets its status flag, and the flag is visible in the cycle after the clock edge that samples the event.
- R4: Writing the status register clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R5: If an event and a clear of the same flag occur in the same cycle, the flag stays set.
- R6: The address pointer reads as follows: address bits 31:7 in bits 31:7, bits 6:1 equal to 0, and the channel in bit 0. The extended pointer holds address bit 32 in bit 0, and bits 7:1 read 0.
- R7: A correctable error that arrives while no ECC flag is set captures its address, channel and syndrome.
- R8: A correctable error that arrives while either ECC flag is set leaves the captured address, channel and syndrome unchanged.
- R9: An uncorrectable error that arrives while the uncorrectable flag is clear captures its address, channel and raw syndrome. This overwrites any correctable capture and leaves the correctable flag set. If both error types arrive in the same cycle, the uncorrectable one is captured.
- R10: An uncorrectable error that arrives while the uncorrectable flag is set leaves the capture unchanged.
- R11: The command register holds enable bits at the same positions as the status flags. `serr_o` is high while any status flag with its enable bit set is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_valid_i | input | 1 | Correctable ECC error event |
| ue_valid_i | input | 1 | Uncorrectable ECC error event |
| err_addr_i | input | 33 | Physical address of the failing access |
| err_chan_i | input | 1 | Channel of the failing access |
| err_syn_i | input | 8 | ECC syndrome |
| refto_i | input | 1 | Refresh timeout event |
| lock_i | input | 1 | Locked access to non-DRAM event |
| therm_i | input | 1 | Thermal sensor event |
| reg_sel_i | input | 3 | Register select |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| serr_o | output | 1 | System error output |

## Verification
The assertions assume the following about the inputs:
- Each event input is a single-cycle-wide, synchronous pulse.
- Address, channel and syndrome are valid in the cycle in which an ECC event is asserted.
- Register writes are single-cycle strobes, driven with a stable select.

The bench drives every input just after the falling edge and holds it for exactly one rising edge before returning it to idle. Register reads are purely combinational, so the bench takes them between edges and never overlaps them with a write.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned FLAG_N  = 5;
  localparam int unsigned ADDR_W  = 33;
  localparam int unsigned SYN_W   = 8;
  localparam int unsigned GRAIN_B = 7;  // 128-byte capture grain
  localparam int unsigned CAP_W   = ADDR_W - GRAIN_B;

  // logical flag index -> bit position in status/command words
  localparam int unsigned F_CE    = 0;
  localparam int unsigned F_UE    = 1;
  localparam int unsigned F_REFTO = 2;
  localparam int unsigned F_LOCK  = 3;
  localparam int unsigned F_THERM = 4;
  localparam int unsigned FLAG_POS [FLAG_N] = '{0, 1, 8, 9, 11};
  localparam logic [REG_W-1:0] FLAG_MASK = 16'h0B03;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_CMD    = 3'd1,
    SEL_ADDR   = 3'd2,
    SEL_EXT    = 3'd3,
    SEL_SYN    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/ecc_flag_bank.sv
module ecc_flag_bank
  import ecc_log_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_N-1:0] ev_i,
  input  logic              wr_st_i,
  input  logic              wr_cmd_i,
  input  logic [FLAG_N-1:0] wbits_i,
  output logic [FLAG_N-1:0] flag_o,
  output logic [FLAG_N-1:0] en_o
);
  logic [FLAG_N-1:0] flag_q, en_q;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic clr;
    assign clr = wr_st_i & wbits_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= ev_i[i] | (flag_q[i] & ~clr);  // event beats clear
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       en_q[i] <= 1'b0;
      else if (wr_cmd_i) en_q[i] <= wbits_i[i];
    end

    a_r3_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[i] |=> flag_q[i]);
    a_r4_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && clr && !ev_i[i]) |=> !flag_q[i]);
    a_r4_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr) |=> flag_q[i]);
    a_r5_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr && ev_i[i]) |=> flag_q[i]);
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
endmodule

// File: rtl/ecc_capture.sv
module ecc_capture
  import ecc_log_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             ue_i,
  input  logic [CAP_W-1:0] addr_i,
  input  logic             chan_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic             ce_logged_i,
  input  logic             ue_logged_i,
  output logic [CAP_W-1:0] addr_o,
  output logic             chan_o,
  output logic [SYN_W-1:0] syn_o
);
  logic [CAP_W-1:0] addr_q;
  logic             chan_q;
  logic [SYN_W-1:0] syn_q;
  logic             load_ue, load_ce, load;

  // UE replaces a CE capture; CE only fills an empty log
  assign load_ue = ue_i & ~ue_logged_i;
  assign load_ce = ce_i & ~ue_i & ~ce_logged_i & ~ue_logged_i;
  assign load    = load_ue | load_ce;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      chan_q <= 1'b0;
      syn_q  <= '0;
    end else if (load) begin
      addr_q <= addr_i;
      chan_q <= chan_i;
      syn_q  <= syn_i;
    end
  end

  assign addr_o = addr_q;
  assign chan_o = chan_q;
  assign syn_o  = syn_q;

  a_r7_ce_captures: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !ce_logged_i && !ue_logged_i) |=> (syn_q == $past(syn_i) && addr_q == $past(addr_i)));
  a_r8_ce_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !ue_i && (ce_logged_i || ue_logged_i)) |=> ($stable(addr_q) && $stable(syn_q) && $stable(chan_q)));
  a_r9_ue_overwrites: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_i && !ue_logged_i) |=> (syn_q == $past(syn_i) && chan_q == $past(chan_i)));
  a_r10_ue_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_logged_i |=> ($stable(addr_q) && $stable(syn_q)));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_valid_i,
  input  logic              ue_valid_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic              err_chan_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic              refto_i,
  input  logic              lock_i,
  input  logic              therm_i,
  input  logic [2:0]        reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              serr_o
);
  logic [FLAG_N-1:0] ev, flag, en, wbits;
  logic [CAP_W-1:0]  cap_addr;
  logic              cap_chan;
  logic [SYN_W-1:0]  cap_syn;
  logic [REG_W-1:0]  st_word, cmd_word;
  logic              wr_st, wr_cmd;
  logic              unused_bits;

  assign ev[F_CE]    = ce_valid_i;
  assign ev[F_UE]    = ue_valid_i;
  assign ev[F_REFTO] = refto_i;
  assign ev[F_LOCK]  = lock_i;
  assign ev[F_THERM] = therm_i;

  assign wr_st  = reg_wr_i && (reg_sel_i == SEL_STATUS);
  assign wr_cmd = reg_wr_i && (reg_sel_i == SEL_CMD);

  for (genvar i = 0; i < FLAG_N; i++) begin : g_wbits
    assign wbits[i] = reg_wdata_i[FLAG_POS[i]];
  end

  assign unused_bits = ^{reg_wdata_i & ~FLAG_MASK, err_addr_i[GRAIN_B-1:0]};

  ecc_flag_bank i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .wr_st_i  (wr_st),
    .wr_cmd_i (wr_cmd),
    .wbits_i  (wbits),
    .flag_o   (flag),
    .en_o     (en)
  );

  ecc_capture i_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_i        (ce_valid_i),
    .ue_i        (ue_valid_i),
    .addr_i      (err_addr_i[ADDR_W-1:GRAIN_B]),
    .chan_i      (err_chan_i),
    .syn_i       (err_syn_i),
    .ce_logged_i (flag[F_CE]),
    .ue_logged_i (flag[F_UE]),
    .addr_o      (cap_addr),
    .chan_o      (cap_chan),
    .syn_o       (cap_syn)
  );

  always_comb begin
    st_word  = '0;
    cmd_word = '0;
    for (int i = 0; i < FLAG_N; i++) begin
      st_word[FLAG_POS[i]]  = flag[i];
      cmd_word[FLAG_POS[i]] = en[i];
    end
  end

  assign serr_o = |(flag & en);

  always_comb begin
    unique case (reg_sel_i)
      SEL_STATUS: reg_rdata_o = {16'h0, st_word};
      SEL_CMD:    reg_rdata_o = {16'h0, cmd_word};
      SEL_ADDR:   reg_rdata_o = {cap_addr[31-GRAIN_B:0], {(GRAIN_B-1){1'b0}}, cap_chan};
      SEL_EXT:    reg_rdata_o = {31'h0, cap_addr[CAP_W-1]};
      SEL_SYN:    reg_rdata_o = {{(32-SYN_W){1'b0}}, cap_syn};
      default:    reg_rdata_o = '0;
    endcase
  end

  a_r11_serr_on_ue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_valid_i && en[F_UE] && !wr_cmd) |=> serr_o);
  a_r11_serr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && reg_wdata_i == 16'h0) |=> !serr_o);
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_word & ~FLAG_MASK) == '0);
  a_r6_ptr_gap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == SEL_ADDR) |-> (reg_rdata_o[GRAIN_B-1:1] == '0));
endmodule

// File: tb/test_ecc_err_log.sv
`timescale 1ns/100ps
module test_ecc_err_log;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_valid_i = 0, ue_valid_i = 0;
  logic [32:0] err_addr_i = '0;
  logic        err_chan_i = 0;
  logic [7:0]  err_syn_i = '0;
  logic        refto_i = 0, lock_i = 0, therm_i = 0;
  logic [2:0]  reg_sel_i = '0;
  logic        reg_wr_i = 0;
  logic [15:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        serr_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  ecc_err_log i_ecc_err_log (.*);

  typedef struct packed {
    logic        ce, ue;
    logic [32:0] addr;
    logic        chan;
    logic [7:0]  syn;
    logic [2:0]  misc;     // {therm, lock, refto}
    logic        we;
    logic [15:0] wd;
    logic [15:0] ex_st;
    logic [31:0] ex_ap;
    logic [7:0]  ex_ext;
    logic [7:0]  ex_syn;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1,0,33'h1_2345_67FF,1,8'h5A,3'b000,0,16'h0000,16'h0001,32'h2345_6781,8'h01,8'h5A,8'd7},  // R7
    '{1,0,33'h0_0000_1000,0,8'h11,3'b000,0,16'h0000,16'h0001,32'h2345_6781,8'h01,8'h5A,8'd8},  // R8
    '{0,1,33'h0_ABCD_EF80,0,8'hC3,3'b000,0,16'h0000,16'h0003,32'hABCD_EF80,8'h00,8'hC3,8'd9},  // R9
    '{0,1,33'h1_0000_0100,1,8'h77,3'b000,0,16'h0000,16'h0003,32'hABCD_EF80,8'h00,8'hC3,8'd10}, // R10
    '{0,0,33'h0,0,8'h00,3'b000,1,16'h0B03,16'h0000,32'hABCD_EF80,8'h00,8'hC3,8'd4},            // R4
    '{1,1,33'h0_5555_5500,1,8'h99,3'b000,0,16'h0000,16'h0003,32'h5555_5501,8'h00,8'h99,8'd9},  // R9 both
    '{1,0,33'h1_0000_0080,0,8'h22,3'b000,1,16'h0001,16'h0003,32'h5555_5501,8'h00,8'h99,8'd5},  // R5
    '{0,0,33'h0,0,8'h00,3'b000,1,16'h0002,16'h0001,32'h5555_5501,8'h00,8'h99,8'd4},            // R4
    '{0,0,33'h0,0,8'h00,3'b100,0,16'h0000,16'h0801,32'h5555_5501,8'h00,8'h99,8'd3},            // R3
    '{0,0,33'h0,0,8'h00,3'b011,0,16'h0000,16'h0B01,32'h5555_5501,8'h00,8'h99,8'd3},            // R3
    '{0,0,33'h0,0,8'h00,3'b000,1,16'hFFFF,16'h0000,32'h5555_5501,8'h00,8'h99,8'd4},            // R4
    '{1,0,33'h1_FFFF_FFFF,0,8'hFF,3'b000,0,16'h0000,16'h0001,32'hFFFF_FF80,8'h01,8'hFF,8'd6}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, input string req, input logic [31:0] exp);
    reg_sel_i = sel;
    #0.5;
    check(req, reg_rdata_o, exp);
  endtask

  task automatic step(input vec_t v, input logic [2:0] wsel);
    @(negedge clk_i);
    ce_valid_i = v.ce; ue_valid_i = v.ue; err_addr_i = v.addr;
    err_chan_i = v.chan; err_syn_i = v.syn;
    {therm_i, lock_i, refto_i} = v.misc;
    reg_sel_i = wsel; reg_wr_i = v.we; reg_wdata_i = v.wd;
    @(posedge clk_i);
    #1;
    ce_valid_i = 0; ue_valid_i = 0; {therm_i, lock_i, refto_i} = '0;
    reg_wr_i = 0;
  endtask

  function automatic vec_t idle_w(input logic [15:0] wd, input logic we);
    vec_t v = '0;
    v.we = we; v.wd = wd;
    return v;
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    rd(0, "R1 status", 32'h0);
    rd(1, "R1 cmd", 32'h0);
    rd(2, "R1 addr", 32'h0);
    rd(3, "R1 ext", 32'h0);
    rd(4, "R1 syn", 32'h0);
    check("R1 serr", {31'h0, serr_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(VEC[k], 3'd0);
      rd(0, $sformatf("R%0d status v%0d", VEC[k].req, k), {16'h0, VEC[k].ex_st});
      rd(2, $sformatf("R%0d addr v%0d", VEC[k].req, k), VEC[k].ex_ap);
      rd(3, $sformatf("R%0d ext v%0d", VEC[k].req, k), {24'h0, VEC[k].ex_ext});
      rd(4, $sformatf("R%0d syn v%0d", VEC[k].req, k), {24'h0, VEC[k].ex_syn});
    end

    // R11 command register and system error (status currently 0x0001)
    step(idle_w(16'hFFFF, 1), 3'd1);
    rd(1, "R11 cmd readback", 32'h0000_0B03);
    check("R11 serr ce enabled", {31'h0, serr_o}, 32'h1);
    step(idle_w(16'h0002, 1), 3'd1);
    check("R11 serr ce masked", {31'h0, serr_o}, 32'h0);
    begin
      vec_t v = '0;
      v.ue = 1; v.addr = 33'h0_0000_4000; v.syn = 8'h3C;
      step(v, 3'd0);
    end
    check("R11 serr ue enabled", {31'h0, serr_o}, 32'h1);
    rd(4, "R9 syn over ce", 32'h3C);
    rd(0, "R9 both flags", 32'h3);
    // R2 unmapped select
    rd(5, "R2 unmapped sel5", 32'h0);
    rd(7, "R2 unmapped sel7", 32'h0);
    step(idle_w(16'hFFFF, 1), 3'd0);
    check("R11 serr after clear", {31'h0, serr_o}, 32'h0);
    rd(0, "R4 all cleared", 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule